// File: doc/BRIEF.md
# Four-Slot Serial Transmit Pattern Store

This block holds four transmit patterns. Each pattern has a drive-high word and a drive-low word. A host loads the patterns one bit at a time over a simple serial link. The link has a serial clock, a data line, an active-low select, a two-bit slot address and a length pin. The length pin picks full-length words or half-length words.

While a slot is being written, its high-drive word and its low-drive word act as one continuous shift chain. Bits enter the high-drive word, pass out of its top into the low-drive word, and leave from the top of the low-drive word on a serial output. That output can feed the next device in a cascade. Every stored word is also presented in parallel, so the playback logic can read any slot at any time.

The serial link has no flow control. A bit is accepted on each rising serial clock edge while the select is low, and the link never pushes back. The block is fully clocked by the serial clock and has an asynchronous active-low reset.

Top module: `pattern_store`

## Requirements
- R1: While reset is asserted, every word of every slot reads zero and the serial output is zero.
- R2: The slot address selects the slot to write: 0 selects slot 0, 1 selects slot 1, 2 selects slot 2 and 3 selects slot 3. Slot k is read at bits [k*HALF_W +: HALF_W] of the matching parallel port.
- R3: While the select is high, no stored bit changes, whatever the data, address or length inputs do.
- R4: On each rising serial clock edge with the select low, the addressed high-drive word shifts up by one position. The data bit enters bit 0. The bit that leaves the top of the active part of the word enters bit 0 of the addressed low-drive word, which also shifts up by one.
- R5: In full-length mode (length pin high), the serial output is the top bit (HALF_W-1) of the addressed low-drive word. The first bit shifted in appears there after 2*HALF_W shifts.
- R6: In half-length mode (length pin low), only bits [HALF_W/2-1:0] of each word shift and the chain is HALF_W bits long. Bits [HALF_W-1:HALF_W/2] keep their values. The serial output is bit HALF_W/2-1 of the addressed low-drive word.
- R7: Slots other than the addressed one keep their contents while the addressed slot is loaded.
- R8: The parallel ports show the stored words one cycle after each shift, without any separate read step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; shifting happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low shift enable |
| sdi | input | 1 | Serial data input |
| pat_sel | input | SEL_W | Slot address |
| wide | input | 1 | Length select: 1 = full HALF_W bits, 0 = HALF_W/2 bits |
| sdo | output | 1 | Serial output from the addressed chain end, for cascading |
| p_words | output | NUM_PAT*HALF_W | All high-drive words, slot k at [k*HALF_W +: HALF_W] |
| n_words | output | NUM_PAT*HALF_W | All low-drive words, slot k at [k*HALF_W +: HALF_W] |

## Verification
The bench uses the defaults: four slots of 32-bit halves. This covers every value of the address, the full 64-bit chain and the 32-bit half-length chain.

A bench model predicts the serial output bit for every cycle, both while shifting and while the select is idle, so the delay through the chain is checked bit by bit. A slot is loaded in full-length mode and then reloaded in half-length mode. The frozen upper bits of that slot then hold non-zero values, so a design that clears or shifts them can be told apart from a correct one.

// File: rtl/pstore_pkg.sv
package pstore_pkg;
  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } width_mode_e;
endpackage

// File: rtl/pstore_decoder.sv
module pstore_decoder #(
  parameter int NUM_PAT = 4,
  parameter int SEL_W   = $clog2(NUM_PAT)
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic               en,
  output logic [NUM_PAT-1:0] hit
);
  for (genvar k = 0; k < NUM_PAT; k++) begin : g_hit
    assign hit[k] = en && (sel == SEL_W'(k));
  end
endmodule

// File: rtl/pstore_half.sv
module pstore_half
  import pstore_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        shift_en,
  input  width_mode_e mode,
  input  logic        din,
  output logic [W-1:0] word,
  output logic        tail
);
  localparam int HW = W / 2;

  logic [W-1:0] shifted;
  logic [W-1:0] bit_en;

  assign shifted = {word[W-2:0], din};

  // lower half shifts in both modes, upper half only at full length
  for (genvar i = 0; i < W; i++) begin : g_en
    if (i < HW) begin : g_lo
      assign bit_en[i] = shift_en;
    end else begin : g_hi
      assign bit_en[i] = shift_en && (mode == MODE_WIDE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else begin
      word <= (word & ~bit_en) | (shifted & bit_en);
    end
  end

  assign tail = (mode == MODE_WIDE) ? word[W-1] : word[HW-1];
endmodule

// File: rtl/pstore_slot.sv
module pstore_slot
  import pstore_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        shift_en,
  input  width_mode_e mode,
  input  logic        din,
  output logic [W-1:0] p_word,
  output logic [W-1:0] n_word,
  output logic        tail
);
  logic p_tail;

  pstore_half #(.W(W)) u_p_half (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .mode     (mode),
    .din      (din),
    .word     (p_word),
    .tail     (p_tail)
  );

  pstore_half #(.W(W)) u_n_half (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .mode     (mode),
    .din      (p_tail),
    .word     (n_word),
    .tail     (tail)
  );
endmodule

// File: rtl/pattern_store.sv
module pattern_store
  import pstore_pkg::*;
#(
  parameter int NUM_PAT = 4,
  parameter int HALF_W  = 32,
  parameter int SEL_W   = $clog2(NUM_PAT)
) (
  input  logic                        sclk,
  input  logic                        rst_n,
  input  logic                        cs_n,
  input  logic                        sdi,
  input  logic [SEL_W-1:0]            pat_sel,
  input  logic                        wide,
  output logic                        sdo,
  output logic [NUM_PAT*HALF_W-1:0]   p_words,
  output logic [NUM_PAT*HALF_W-1:0]   n_words
);
  localparam int TOTAL_W = NUM_PAT * HALF_W;

  width_mode_e          mode;
  logic [NUM_PAT-1:0]   slot_hit;
  logic [NUM_PAT-1:0]   slot_tail;
  logic [TOTAL_W-1:0]   p_flat;
  logic [TOTAL_W-1:0]   n_flat;

  assign mode = width_mode_e'(wide);

  pstore_decoder #(.NUM_PAT(NUM_PAT), .SEL_W(SEL_W)) u_dec (
    .sel (pat_sel),
    .en  (!cs_n),
    .hit (slot_hit)
  );

  for (genvar k = 0; k < NUM_PAT; k++) begin : g_slot
    pstore_slot #(.W(HALF_W)) u_slot (
      .clk      (sclk),
      .rst_n    (rst_n),
      .shift_en (slot_hit[k]),
      .mode     (mode),
      .din      (sdi),
      .p_word   (p_flat[k*HALF_W +: HALF_W]),
      .n_word   (n_flat[k*HALF_W +: HALF_W]),
      .tail     (slot_tail[k])
    );
  end

  assign sdo     = slot_tail[pat_sel];
  assign p_words = p_flat;
  assign n_words = n_flat;
endmodule

// File: rtl/pattern_store_checker.sv
module pattern_store_checker #(
  parameter int NUM_PAT = 4,
  parameter int HALF_W  = 32,
  parameter int SEL_W   = $clog2(NUM_PAT)
) (
  input logic                      sclk,
  input logic                      rst_n,
  input logic                      cs_n,
  input logic                      sdi,
  input logic [SEL_W-1:0]          pat_sel,
  input logic                      wide,
  input logic                      sdo,
  input logic [NUM_PAT*HALF_W-1:0] p_words,
  input logic [NUM_PAT*HALF_W-1:0] n_words
);
  localparam int TOTAL_W = NUM_PAT * HALF_W;
  localparam int IDX_W   = $clog2(TOTAL_W);
  localparam int HW      = HALF_W / 2;

  logic [IDX_W-1:0] base_now;
  logic [IDX_W-1:0] tail_prev_idx;
  assign base_now      = IDX_W'(pat_sel) * IDX_W'(HALF_W);
  assign tail_prev_idx = base_now + IDX_W'(HALF_W - 2);

  // R3: select high freezes every stored bit
  assert_hold_when_idle_R3: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |=> ($stable(p_words) && $stable(n_words)));

  // R4: the data bit lands in bit 0 of the addressed high-drive word
  assert_entry_bit_R4: assert property (@(posedge sclk) disable iff (!rst_n)
    !cs_n |=> (p_words[$past(base_now)] == $past(sdi)));

  // R5: at full length the output follows the chain one step on
  assert_chain_out_R5: assert property (@(posedge sclk) disable iff (!rst_n)
    (!cs_n && wide) |=> ((pat_sel != $past(pat_sel)) || !wide ||
                         (sdo == $past(n_words[tail_prev_idx]))));

  for (genvar k = 0; k < NUM_PAT; k++) begin : g_slot_chk
    // R6: upper bits stay put at half length
    assert_upper_frozen_R6: assert property (@(posedge sclk) disable iff (!rst_n)
      !wide |=> ($stable(p_words[k*HALF_W+HW +: HW]) &&
                 $stable(n_words[k*HALF_W+HW +: HW])));
    // R7: other slots untouched during a load
    assert_other_slot_hold_R7: assert property (@(posedge sclk) disable iff (!rst_n)
      (!cs_n && (pat_sel != SEL_W'(k))) |=>
        ($stable(p_words[k*HALF_W +: HALF_W]) && $stable(n_words[k*HALF_W +: HALF_W])));
  end
endmodule

bind pattern_store pattern_store_checker #(
  .NUM_PAT (NUM_PAT),
  .HALF_W  (HALF_W),
  .SEL_W   (SEL_W)
) u_checker (
  .sclk    (sclk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .sdi     (sdi),
  .pat_sel (pat_sel),
  .wide    (wide),
  .sdo     (sdo),
  .p_words (p_words),
  .n_words (n_words)
);

// File: tb/pattern_store_bench.sv
`timescale 1ns/1ps
module pattern_store_bench;
  localparam int NP = 4;
  localparam int HW = 32;

  logic            sclk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cs_n = 1'b1;
  logic            sdi = 1'b0;
  logic [1:0]      pat_sel = 2'd0;
  logic            wide = 1'b1;
  logic            sdo;
  logic [NP*HW-1:0] p_words;
  logic [NP*HW-1:0] n_words;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [HW-1:0] mp [NP];
  logic [HW-1:0] mn [NP];
  logic          exp_q [$];
  logic [31:0]   lfsr = 32'hACE1_2B57;

  always #2 sclk = ~sclk;

  pattern_store #(.NUM_PAT(NP), .HALF_W(HW)) u_pattern_store (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .pat_sel(pat_sel),
    .wide(wide), .sdo(sdo), .p_words(p_words), .n_words(n_words)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[0];
  endfunction

  // model: expected tail bit for a slot at the current length
  function automatic logic model_tail(input int s, input logic w);
    return w ? mn[s][HW-1] : mn[s][HW/2-1];
  endfunction

  // driver: one shift, model update, expected output pushed
  task automatic shift_bit(input int s, input logic w, input logic b);
    int len;
    logic carry;
    @(negedge sclk);
    cs_n = 1'b0; sdi = b; pat_sel = 2'(s); wide = w;
    len = w ? HW : HW / 2;
    carry = mp[s][len-1];
    for (int j = len - 1; j > 0; j--) mp[s][j] = mp[s][j-1];
    mp[s][0] = b;
    for (int j = len - 1; j > 0; j--) mn[s][j] = mn[s][j-1];
    mn[s][0] = carry;
    exp_q.push_back(model_tail(s, w));
  endtask

  task automatic load(input int s, input logic w, input int nbits, output logic first);
    logic b;
    first = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      b = next_bit();
      if (i == 0) first = b;
      shift_bit(s, w, b);
    end
    @(negedge sclk);
    cs_n = 1'b1;
  endtask

  // select high with busy inputs; output expected to track held state
  task automatic idle(input int n);
    logic w;
    for (int i = 0; i < n; i++) begin
      @(negedge sclk);
      cs_n = 1'b1; sdi = next_bit(); pat_sel = 2'(i % NP); w = next_bit(); wide = w;
      exp_q.push_back(model_tail(i % NP, w));
    end
  endtask

  task automatic check_words(input string tag);
    for (int k = 0; k < NP; k++) begin
      chk(p_words[k*HW +: HW] === mp[k], tag, $sformatf("p slot %0d", k), p_words[k*HW +: HW], mp[k]);
      chk(n_words[k*HW +: HW] === mn[k], tag, $sformatf("n slot %0d", k), n_words[k*HW +: HW], mn[k]);
    end
  endtask

  // monitor: compares output after every edge that has an expectation
  initial begin
    forever begin
      @(posedge sclk);
      #1;
      if (exp_q.size() > 0) begin
        logic e;
        e = exp_q.pop_front();
        chk(sdo === e, "R5", "serial output", {31'd0, sdo}, {31'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge sclk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic first;
    for (int k = 0; k < NP; k++) begin mp[k] = '0; mn[k] = '0; end
    repeat (3) @(negedge sclk);
    check_words("R1");
    chk(sdo === 1'b0, "R1", "sdo in reset", {31'd0, sdo}, 32'd0);
    rst_n = 1'b1;

    // R2 R4 R5 R8: full-length load of slot 0, first bit at output after 64 shifts
    load(0, 1'b1, 2 * HW, first);
    chk(sdo === first, "R5", "first bit at chain end", {31'd0, sdo}, {31'd0, first});
    check_words("R8");

    // R2 R7: slot 2 load leaves slot 0 intact
    load(2, 1'b1, 2 * HW, first);
    check_words("R7");

    // R3: select high while inputs toggle
    idle(20);
    check_words("R3");

    // R6: half-length load of slot 1, 32-bit chain
    load(1, 1'b0, HW, first);
    chk(sdo === first, "R6", "first bit after half-length chain", {31'd0, sdo}, {31'd0, first});
    check_words("R6");

    // R6: half-length reload of a full slot keeps its upper bits
    load(0, 1'b0, HW + 5, first);
    check_words("R6");

    // R2: last slot, then partial load and idle
    load(3, 1'b1, 2 * HW + 7, first);
    check_words("R2");
    idle(10);
    check_words("R3");

    repeat (3) @(negedge sclk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule